// File: doc/BRIEF.md
# Serial DAC Word Receiver and Output Latch

This block is the digital receive path of a 16-bit serial-input digital-to-analog converter. It runs on a fast system clock. The serial clock, chip-select, data and load-strobe lines are resynchronized and edge-detected inside the block. Data bits are shifted in most significant bit first, one per rising serial-clock edge, while chip-select is low. The block counts the bits of each frame. The finished word is then committed to a double-buffered output latch that drives the converter code.

Two commit modes are supported, chosen by a static mode input. In three-wire mode the word reaches the output latch when chip-select is released. In four-wire mode a completed word is parked in a holding register, and a later falling edge on the active-low load strobe moves it to the output. In both modes a frame that does not carry exactly 16 bits is rejected and flagged with a one-cycle error pulse. Reset clears the output code to zero.

Top module: `serdac_rx`

## Requirements
- R1: While reset is asserted and after it is released with no further activity, `dac_code` is 0x0000 and neither `dac_update` nor `frame_error` pulses.
- R2: In three-wire mode (`four_wire`=0), a frame of exactly 16 serial-clock rising edges between a chip-select fall and the following rise sets `dac_code` to the received word. The first bit sent is bit 15 and the last is bit 0.
- R3: A frame whose rising serial-clock count at chip-select release is not 16 (0, 15 and 17 included) leaves `dac_code` unchanged and produces exactly one single-cycle `frame_error` pulse.
- R4: In four-wire mode (`four_wire`=1), a valid frame does not change `dac_code`. The next falling edge of `ldac_n` sets `dac_code` to that word.
- R5: In four-wire mode, a falling edge of `ldac_n` with no word waiting leaves `dac_code` unchanged and gives no `dac_update` pulse. A word is consumed by the edge that loads it.
- R6: In four-wire mode, the word loaded by `ldac_n` is the most recent valid frame. A later invalid frame does not alter it.
- R7: In three-wire mode, edges on `ldac_n` have no effect on `dac_code` or `dac_update`.
- R8: Every change of `dac_code` occurs in a cycle where `dac_update` is high. `dac_update` is high for exactly one cycle per load.
- R9: Serial-clock edges while chip-select is high do not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock, asynchronous |
| csn_in | input | 1 | Active-low chip-select, asynchronous |
| din_in | input | 1 | Serial data, asynchronous |
| ldac_n | input | 1 | Active-low load strobe (four-wire mode), asynchronous |
| four_wire | input | 1 | 1 selects strobe commit, 0 selects commit on chip-select release |
| dac_code | output | 16 | Converter code from the output latch |
| dac_update | output | 1 | One-cycle pulse on each output latch load |
| frame_error | output | 1 | One-cycle pulse for a frame of the wrong length |

## Verification
The bench sends frames that are one bit short, one bit long and empty. A design that counted loosely or let the count wrap would load a truncated word instead of raising the error. In four-wire mode it sends two valid frames before one strobe, which exposes a design that keeps the first word. It also places an invalid frame between a valid frame and its strobe, which shows up a design that reads the live shift register rather than a holding copy. Strobes with nothing waiting, and strobe edges in three-wire mode, would show up as spurious loads or extra update pulses.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
    localparam int CODE_W = 16;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] hold;
        logic              pend;
        logic              upd;
        logic              err;
    } latch_state_t;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
    parameter int          N       = 4,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] chain_q [STAGES];
    logic [N-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 2)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_low,
    input  logic         cs_fall,
    input  logic         cs_rise,
    input  logic         sclk_rise,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         done,
    output logic         valid
);
    localparam logic [CW-1:0] FULL = CW'(W);
    localparam logic [CW-1:0] OVER = CW'(W + 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
    } shift_state_t;

    shift_state_t q, d;

    always_comb begin
        d = q;
        if (cs_fall) begin
            d.cnt = '0;
        end else if (cs_low && sclk_rise && !cs_rise) begin
            d.sh = {q.sh[W-2:0], din};
            if (q.cnt != OVER) d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word  = q.sh;
    assign done  = cs_rise;
    assign valid = (q.cnt == FULL);
endmodule

// File: rtl/serdac_latch.sv
module serdac_latch
    import serdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              four_wire,
    input  logic              done,
    input  logic              valid,
    input  logic [CODE_W-1:0] word,
    input  logic              ld_fall,
    output logic [CODE_W-1:0] code,
    output logic              update,
    output logic              error,
    output logic              pending
);
    latch_state_t q, d;

    always_comb begin
        d     = q;
        d.upd = 1'b0;
        d.err = 1'b0;
        if (four_wire && ld_fall && q.pend) begin
            d.code = q.hold;
            d.pend = 1'b0;
            d.upd  = 1'b1;
        end
        if (done) begin
            if (!valid) begin
                d.err = 1'b1;
            end else if (four_wire) begin
                d.hold = word;
                d.pend = 1'b1;
            end else begin
                d.code = word;
                d.upd  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign code    = q.code;
    assign update  = q.upd;
    assign error   = q.err;
    assign pending = q.pend;
endmodule

// File: rtl/serdac_rx.sv
module serdac_rx
    import serdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              csn_in,
    input  logic              din_in,
    input  logic              ldac_n,
    input  logic              four_wire,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_update,
    output logic              frame_error
);
    // bit order in the synchronized vector: {ldac, cs, din, sclk}
    localparam logic [3:0] IDLE_LVL = 4'b1100;

    typedef struct packed {
        logic ld;
        logic cs;
        logic sclk;
    } prev_t;

    logic [3:0] sync_v;
    prev_t      prev_q, prev_d;
    logic       sclk_rise, cs_fall, cs_rise, ld_fall;
    logic [CODE_W-1:0] word;
    logic       done, valid, pend;

    serdac_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ldac_n, csn_in, din_in, sclk_in}),
        .sync_out (sync_v)
    );

    always_comb begin
        prev_d.ld   = sync_v[3];
        prev_d.cs   = sync_v[2];
        prev_d.sclk = sync_v[0];
        sclk_rise   = sync_v[0] && !prev_q.sclk;
        cs_fall     = !sync_v[2] && prev_q.cs;
        cs_rise     = sync_v[2] && !prev_q.cs;
        ld_fall     = !sync_v[3] && prev_q.ld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{ld: 1'b1, cs: 1'b1, sclk: 1'b0};
        else        prev_q <= prev_d;
    end

    serdac_shifter #(.W(CODE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_low    (!sync_v[2]),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .din       (sync_v[1]),
        .word      (word),
        .done      (done),
        .valid     (valid)
    );

    serdac_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .four_wire (four_wire),
        .done      (done),
        .valid     (valid),
        .word      (word),
        .ld_fall   (ld_fall),
        .code      (dac_code),
        .update    (dac_update),
        .error     (frame_error),
        .pending   (pend)
    );
endmodule

// File: rtl/serdac_rx_chk.sv
module serdac_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        four_wire,
    input logic [15:0] dac_code,
    input logic        dac_update,
    input logic        frame_error,
    input logic        pend
);
    a_r1_reset_code_zero: assert property (@(posedge clk)
        !rst_n |-> dac_code == 16'h0000);

    a_r8_code_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_update |-> $stable(dac_code));

    a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dac_update |=> !dac_update);

    a_r3_error_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |=> !frame_error);

    a_r5_no_load_without_word: assert property (@(posedge clk) disable iff (!rst_n)
        (four_wire && !pend) |=> !dac_update);
endmodule

bind serdac_rx serdac_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .four_wire   (four_wire),
    .dac_code    (dac_code),
    .dac_update  (dac_update),
    .frame_error (frame_error),
    .pend        (pend)
);

// File: tb/sim_serdac_rx.sv
`timescale 1ns/1ps
module sim_serdac_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0, csn_in = 1'b1, din_in = 1'b0, ldac_n = 1'b0, four_wire = 1'b0;
    logic [15:0] dac_code;
    logic        dac_update, frame_error;

    int checks = 0, fails = 0;
    int upd_seen = 0, err_seen = 0;
    int exp_upd = 0, exp_err = 0;
    logic [15:0] exp_code = 16'h0000, exp_hold = 16'h0000;
    bit          exp_pend = 1'b0;

    always #10 clk = ~clk;

    serdac_rx u0 (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .csn_in(csn_in), .din_in(din_in),
        .ldac_n(ldac_n), .four_wire(four_wire), .dac_code(dac_code),
        .dac_update(dac_update), .frame_error(frame_error)
    );

    always @(negedge clk) begin
        if (rst_n && dac_update)  upd_seen++;
        if (rst_n && frame_error) err_seen++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic verify(input string req);
        check(dac_code == exp_code, {req, " code"}, dac_code, exp_code);
        check(upd_seen == exp_upd, {req, " update count"}, upd_seen, exp_upd);
        check(err_seen == exp_err, {req, " error count"}, err_seen, exp_err);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bench model of a finished frame
    function automatic void model_frame(input logic [15:0] w, input int nbits);
        if (nbits != 16) exp_err++;
        else if (four_wire) begin exp_hold = w; exp_pend = 1'b1; end
        else begin exp_code = w; exp_upd++; end
    endfunction

    function automatic void model_strobe();
        if (four_wire && exp_pend) begin exp_code = exp_hold; exp_pend = 1'b0; exp_upd++; end
    endfunction

    task automatic send_frame(input logic [15:0] w, input int nbits);
        @(negedge clk); csn_in = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            sclk_in = 1'b0; din_in = w[15 - (i % 16)];
            wait_clk(3);
            sclk_in = 1'b1;
            wait_clk(3);
        end
        sclk_in = 1'b0;
        wait_clk(3);
        csn_in = 1'b1;
        wait_clk(8);
        model_frame(w, nbits);
    endtask

    task automatic strobe();
        ldac_n = 1'b0; wait_clk(4);
        ldac_n = 1'b1; wait_clk(6);
        model_strobe();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0a17));
        wait_clk(5);
        verify("R1 in reset");
        rst_n = 1'b1;
        wait_clk(10);
        verify("R1 after reset");

        // three-wire mode
        send_frame(16'hA55A, 16);  verify("R2 word A55A");
        send_frame(16'h8001, 16);  verify("R2 word 8001 msb first");
        send_frame(16'h1234, 15);  verify("R3 short frame");
        send_frame(16'h4321, 17);  verify("R3 long frame");
        send_frame(16'h0000, 0);   verify("R3 empty frame");
        ldac_n = 1'b1; wait_clk(6); ldac_n = 1'b0; wait_clk(8);
        verify("R7 strobe ignored in three-wire");
        for (int k = 0; k < 5; k++) begin
            sclk_in = 1'b1; wait_clk(3); sclk_in = 1'b0; wait_clk(3);
        end
        send_frame(16'h00FF, 16);  verify("R9 idle clocks ignored");
        for (int k = 0; k < 12; k++) begin
            logic [15:0] w = 16'($urandom);
            int nb = ($urandom % 4 == 0) ? 14 + int'($urandom % 5) : 16;
            send_frame(w, nb); verify("R2 R3 random three-wire");
        end

        // four-wire mode
        ldac_n = 1'b1; wait_clk(6);
        four_wire = 1'b1; wait_clk(2);
        strobe();                   verify("R5 strobe with nothing waiting");
        send_frame(16'hBEEF, 16);   verify("R4 held before strobe");
        strobe();                   verify("R4 strobe loads word");
        strobe();                   verify("R5 word consumed");
        send_frame(16'h1111, 16);
        send_frame(16'h2222, 16);
        strobe();                   verify("R6 newest valid word");
        send_frame(16'h3C3C, 16);
        send_frame(16'hFFFF, 15);   verify("R3 invalid in four-wire");
        strobe();                   verify("R6 invalid frame leaves held word");
        for (int k = 0; k < 12; k++) begin
            logic [15:0] w = 16'($urandom);
            int nb = ($urandom % 4 == 0) ? 15 + int'($urandom % 3) : 16;
            send_frame(w, nb);
            if ($urandom % 2 == 0) strobe();
            verify("R4 R6 R8 random four-wire");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule